// File: doc/BRIEF.md
# Dual-Output Deadtime PWM Controller

This block is a fixed-frequency digital pulse-width modulator for a switching-supply control loop. A free-running up-counter acts as the ramp. The counter runs from zero up to a programmable period value and then wraps. In every cycle the ramp is compared against one effective threshold. That threshold is the largest of five values: two error codes, a feedback code, a deadtime code, and a built-in minimum deadtime derived from the period. The modulated pulse is high only while the ramp is strictly above the threshold, so a larger control value gives a linearly shorter pulse.

A steering toggle routes the modulated pulse to two outputs. In alternating mode the pulses of successive ramp periods go to Q1 and Q2 in turn, starting with Q1. In single-ended mode both outputs carry every pulse. All control codes, the period and the mode are captured when a ramp period begins, so a change in mid-period cannot cut a pulse short. A one-cycle strobe marks the first cycle of every ramp period.

Top module: `pwm_deadtime_ctrl`

## Requirements
- R1: While rst_n is low, or in the cycle after en is sampled low, q1, q2 and period_start are all 0. After en rises, the first ramp period begins on the next clock edge.
- R2: A ramp period lasts period+1 clock cycles, with the ramp counting 0 to period. period_start is 1 exactly in the cycle where the ramp is 0.
- R3: The two error codes combine by maximum: the pulse is high only in cycles whose ramp value is strictly greater than both err_a and err_b.
- R4: A minimum deadtime of max(floor(period/25), 1) counts always applies. The pulse can never be high while the ramp is at or below that value.
- R5: dt_code raises the threshold in the same way. A ramp value must exceed dt_code for the pulse to be high.
- R6: Sweeping fb_code from 0 up past period shortens the pulse by one cycle per step, down to no pulse once fb_code is at least period.
- R7: With push_pull=1, the pulse of the first period after enable goes to q1 only, the next to q2 only, and so on alternately. q1 and q2 are never high together.
- R8: With push_pull=0, q1 and q2 both carry the pulse in every ramp period and are equal in every cycle.
- R9: err_a, err_b, fb_code, dt_code, push_pull and period are captured on the edge that starts a ramp period. A change made later in that period takes effect only from the next period.
- R10: In the cycle where period_start is 1, both q1 and q2 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low stops and clears the ramp and steering |
| err_a | input | 8 | First error code |
| err_b | input | 8 | Second error code |
| fb_code | input | 8 | Feedback code |
| dt_code | input | 8 | Extra deadtime threshold |
| push_pull | input | 1 | 1 = alternate outputs, 0 = both outputs together |
| period | input | 8 | Last ramp value before the ramp wraps |
| q1 | output | 1 | First steered output |
| q2 | output | 1 | Second steered output |
| period_start | output | 1 | High in the first cycle of each ramp period |

## Verification
The bench tries the comparator with each control input acting alone as the highest threshold: the error pair with either member larger, the deadtime code, and the built-in floor with a long and a short period. A mismatch then points to the path of one single input. A full sweep of fb_code across a short ramp compares the pulse length at every step, which exposes off-by-one comparisons at both ends of the range. Runs in alternating and single-ended mode tell the steering variants apart. A run with a mid-period change of an error code separates per-period capture from live tracking. Dropping en between runs shows that the outputs clear and that the steering always restarts on q1.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
    typedef enum logic {
        STEER_SINGLE = 1'b0,
        STEER_ALT    = 1'b1
    } steer_e;
endpackage

// File: rtl/pwm_limit.sv
// Effective threshold: maximum of all control codes and the period-derived floor.
module pwm_limit #(
    parameter int W      = 8,
    parameter int DT_DIV = 25
) (
    input  logic [W-1:0] err_a,
    input  logic [W-1:0] err_b,
    input  logic [W-1:0] fb_code,
    input  logic [W-1:0] dt_code,
    input  logic [W-1:0] period,
    output logic [W-1:0] thr
);
    localparam int            NCAND = 4;
    localparam logic [W-1:0]  DIV_W = W'(DT_DIV);
    localparam logic [W-1:0]  ONE   = W'(1);

    logic [W-1:0] cand [NCAND];
    logic [W-1:0] quo;
    logic [W-1:0] floor_v;

    always_comb begin
        cand[0] = err_a;
        cand[1] = err_b;
        cand[2] = fb_code;
        cand[3] = dt_code;
        quo     = period / DIV_W;
        floor_v = (quo == '0) ? ONE : quo;
        thr     = floor_v;
        for (int i = 0; i < NCAND; i++) begin
            if (cand[i] > thr) thr = cand[i];
        end
    end
endmodule

// File: rtl/pwm_ramp.sv
// Ramp counter with per-period capture of the wrap value.
module pwm_ramp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] period,
    output logic         load,
    output logic         run,
    output logic [W-1:0] cnt,
    output logic         strobe
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] per;
        logic         run;
    } ramp_t;

    ramp_t st_d, st_q;

    always_comb begin
        load = en && (!st_q.run || st_q.cnt == st_q.per);
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
            st_d.run = 1'b0;
        end else if (load) begin
            st_d.cnt = '0;
            st_d.run = 1'b1;
            st_d.per = period;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run    = st_q.run;
    assign cnt    = st_q.cnt;
    assign strobe = st_q.run && (st_q.cnt == '0);

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.run && st_q.cnt == st_q.per) |=> (st_q.cnt == '0 && st_q.run));

    a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt != '0) |-> $stable(st_q.per));
endmodule

// File: rtl/pwm_steer.sv
// Captures threshold and mode per period and steers the modulated pulse.
module pwm_steer
    import pwm_dt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] thr_in,
    input  steer_e       mode_in,
    output logic         q1,
    output logic         q2
);
    typedef struct packed {
        logic [W-1:0] thr;
        steer_e       mode;
        logic         tog;
    } steer_t;

    steer_t st_d, st_q;
    logic   pulse;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.tog = 1'b0;
        end else if (load) begin
            st_d.thr  = thr_in;
            st_d.mode = mode_in;
            st_d.tog  = (!run || mode_in == STEER_SINGLE) ? 1'b0 : ~st_q.tog;
        end
        pulse = run && (cnt > st_q.thr);
        q1    = pulse && (st_q.mode == STEER_SINGLE || !st_q.tog);
        q2    = pulse && (st_q.mode == STEER_SINGLE ||  st_q.tog);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr  <= '1;
            st_q.mode <= STEER_SINGLE;
            st_q.tog  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == STEER_ALT) |-> !(q1 && q2));

    a_r8_twin: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == STEER_SINGLE) |-> (q1 == q2));

    a_r9_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |-> $stable(st_q.thr));
endmodule

// File: rtl/pwm_deadtime_ctrl.sv
module pwm_deadtime_ctrl
    import pwm_dt_pkg::*;
#(
    parameter int W      = 8,
    parameter int DT_DIV = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] err_a,
    input  logic [W-1:0] err_b,
    input  logic [W-1:0] fb_code,
    input  logic [W-1:0] dt_code,
    input  logic         push_pull,
    input  logic [W-1:0] period,
    output logic         q1,
    output logic         q2,
    output logic         period_start
);
    logic         load;
    logic         run;
    logic [W-1:0] cnt;
    logic [W-1:0] thr;
    steer_e       mode_in;

    assign mode_in = push_pull ? STEER_ALT : STEER_SINGLE;

    pwm_limit #(.W(W), .DT_DIV(DT_DIV)) u_limit (
        .err_a   (err_a),
        .err_b   (err_b),
        .fb_code (fb_code),
        .dt_code (dt_code),
        .period  (period),
        .thr     (thr)
    );

    pwm_ramp #(.W(W)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .period (period),
        .load   (load),
        .run    (run),
        .cnt    (cnt),
        .strobe (period_start)
    );

    pwm_steer #(.W(W)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (load),
        .run     (run),
        .cnt     (cnt),
        .thr_in  (thr),
        .mode_in (mode_in),
        .q1      (q1),
        .q2      (q2)
    );

    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!q1 && !q2 && !period_start));

    a_r10_blank: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (!q1 && !q2));
endmodule

// File: tb/tb_pwm_deadtime_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_deadtime_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] err_a = '0, err_b = '0, fb_code = '0, dt_code = '0, period = 8'd99;
    logic       push_pull = 1'b0;
    logic       q1, q2, period_start;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pwm_deadtime_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .err_a(err_a), .err_b(err_b), .fb_code(fb_code), .dt_code(dt_code),
        .push_pull(push_pull), .period(period),
        .q1(q1), .q2(q2), .period_start(period_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_thr(input int p, input int a, input int b, input int f, input int d);
        int m;
        m = p / 25;
        if (m < 1) m = 1;
        if (a > m) m = a;
        if (b > m) m = b;
        if (f > m) m = f;
        if (d > m) m = d;
        return m;
    endfunction

    task automatic run_cfg(input int p, input int a, input int b, input int f, input int d,
                           input bit pp, input int periods, input int chg_at,
                           input int chg_val, input string tag);
        int k, n, act, idx;
        bit pulse, e1, e2;
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(q1 == 1'b0 && q2 == 1'b0 && period_start == 1'b0, "R1",
            int'({q1, q2, period_start}), 0);
        period = 8'(p); err_a = 8'(a); err_b = 8'(b); fb_code = 8'(f); dt_code = 8'(d);
        push_pull = pp;
        en = 1'b1;
        k = p; n = -1; act = 0; idx = 0;
        repeat (periods * (p + 1)) begin
            @(negedge clk);
            k = (k == p) ? 0 : k + 1;
            if (k == 0) begin
                n++;
                act = model_thr(p, int'(err_a), int'(err_b), int'(fb_code), int'(dt_code));
            end
            pulse = (k > act);
            e1 = pulse && (!pp || (n % 2 == 0));
            e2 = pulse && (!pp || (n % 2 == 1));
            chk(q1 == e1, tag, int'(q1), int'(e1));
            chk(q2 == e2, tag, int'(q2), int'(e2));
            chk(period_start == (k == 0), "R2", int'(period_start), int'(k == 0));
            if (k == 0) chk(!q1 && !q2, "R10", int'({q1, q2}), 0);
            idx++;
            if (idx == chg_at) err_a = 8'(chg_val);
        end
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        // R1: outputs held low during reset even with en high
        en = 1'b1; err_a = 8'd5;
        @(negedge clk);
        @(negedge clk);
        chk(q1 == 1'b0 && q2 == 1'b0 && period_start == 1'b0, "R1",
            int'({q1, q2, period_start}), 0);
        rst_n = 1'b1;
        run_cfg(99, 30, 60, 0, 0, 1'b0, 2, -1, 0, "R3");
        run_cfg(99, 70, 10, 0, 0, 1'b0, 2, -1, 0, "R3");
        run_cfg(99, 0, 0, 0, 0, 1'b0, 2, -1, 0, "R4");
        run_cfg(20, 0, 0, 0, 0, 1'b0, 3, -1, 0, "R4");
        run_cfg(99, 10, 0, 0, 50, 1'b0, 2, -1, 0, "R5");
        for (int f = 0; f <= 31; f++) begin
            run_cfg(30, 0, 0, f, 0, 1'b0, 2, -1, 0, "R6");
        end
        run_cfg(49, 5, 20, 0, 0, 1'b1, 5, -1, 0, "R7");
        run_cfg(49, 0, 0, 10, 0, 1'b0, 3, -1, 0, "R8");
        run_cfg(49, 10, 0, 0, 0, 1'b1, 3, 25, 40, "R9");
        run_cfg(255, 0, 0, 0, 0, 1'b1, 2, -1, 0, "R7");
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(q1 == 1'b0 && q2 == 1'b0 && period_start == 1'b0, "R1",
            int'({q1, q2, period_start}), 0);
        finish_up();
    end
endmodule